// File: doc/BRIEF.md
# Buffered Match PWM Output Channel

This block is one channel of a timer. A counter that lives outside the channel drives a shared count bus. The channel compares that bus against two compare values and produces a pulse-width-modulated pin level. The first compare value, A, starts the active part of each period. The second, B, ends it and marks the end of the period. Software does not write the live A value directly. Its writes go into a staging register, and the staged value becomes the live A value on the next B match. This lets the duty cycle change cleanly at a period edge.

A match counts only on the prescaled tick where equality first becomes true, not on every tick where it holds. When A and B match on the same tick, A takes precedence and the pin stays at its inactive level. Programming equal A and B values therefore gives a real 0% duty cycle. Each B match also raises a sticky flag, which software clears by writing a one.

Top module: `pwm_match_chan`

## Requirements
- R1: While rst_n is low at a clock edge, the staged A value, the live A value and B all become zero, match_flag becomes 0, and pwm_out equals out_pol.
- R2: A match event for A or B happens only on a tick (tick_en high) where cnt_bus equals the compare value and did not equal it on the previous tick. Holding cnt_bus at the compare value over further ticks produces no further event.
- R3: An A match event without a B match event on the same tick makes pwm_out equal to the inverse of out_pol from the next clock onward.
- R4: A B match event without an A match event makes pwm_out equal to out_pol from the next clock onward.
- R5: When A and B match events occur on the same tick, pwm_out stays at or returns to out_pol. If the live A value equals B in every period, pwm_out never leaves out_pol.
- R6: A write with wr_stage_a high loads wr_data into the staging register only. The live A value takes the staging value held just before a B match event, at that event. An A value staged during a period therefore first applies in the period after the next B match.
- R7: A B match event sets match_flag on the next clock. A flag_clr pulse clears the flag. When a B match event and flag_clr fall on the same clock, the flag is set.
- R8: pwm_out is the internal active state XOR out_pol, so a change of out_pol shows on pwm_out at once without waiting for a clock.
- R9: On clocks with tick_en low, no match is detected and changes of cnt_bus have no effect on pwm_out or match_flag.
- R10: A write with wr_period_b high loads wr_data into B directly, and it applies from the next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_bus | input | 24 | Shared counter value from the external time base |
| tick_en | input | 1 | Prescaled tick; matches are sampled only when high |
| wr_stage_a | input | 1 | Write strobe for the A staging register |
| wr_period_b | input | 1 | Write strobe for the B compare register |
| wr_data | input | 24 | Write data for either register |
| flag_clr | input | 1 | Write-one-to-clear for match_flag |
| out_pol | input | 1 | Inactive pin level; the active level is its inverse |
| pwm_out | output | 1 | PWM pin level |
| match_flag | output | 1 | Sticky flag set by each B match |

## Verification
Two pairs of functions can land on the same clock. The first pair is the A and B match events. The bench provokes this by programming equal A and B values. It judges the result by counting every clock over several periods on which pwm_out differs from out_pol, and that count must be zero. The second pair is the flag set and the software clear. The bench holds flag_clr high across a whole period, so the clear coincides with the B match. It then requires the flag to be seen high on the clock after the match. A behavioural model runs alongside and compares pwm_out and match_flag on every clock.

// File: rtl/pwm_chan_pkg.sv
`timescale 1ns/1ps
// Package pwm_chan_pkg
// Shared width and event type for the buffered match PWM channel.
// Assumes a single count bus width for both compare values.
package pwm_chan_pkg;
    localparam int CNT_W   = 24;
    localparam int N_MATCH = 2;
    localparam int IDX_A   = 0;
    localparam int IDX_B   = 1;

    typedef struct packed {
        logic hit_a;
        logic hit_b;
    } match_ev_t;
endpackage

// File: rtl/pwm_edge_match.sv
`timescale 1ns/1ps
// Module pwm_edge_match
// Compares the count bus with one compare value and reports a single-cycle
// event on the tick where equality first becomes true.
// Assumes tick marks the clocks on which the count bus is meaningful.
module pwm_edge_match #(
    parameter int W = pwm_chan_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] bus,
    input  logic [W-1:0] cmp,
    output logic         hit
);
    logic eq_now;
    logic eq_seen;

    assign eq_now = (bus == cmp);

    // Remember the equality seen on the last tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    eq_seen <= 1'b0;
        else if (tick) eq_seen <= eq_now;
    end

    assign hit = tick & eq_now & ~eq_seen;

    // R2: an event is never followed directly by another one
    a_r2_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);
endmodule

// File: rtl/pwm_cmp_regs.sv
`timescale 1ns/1ps
// Module pwm_cmp_regs
// Holds the staged A value, the live A value and the B value.
// The live A value is refreshed from staging when xfer (B match) pulses.
module pwm_cmp_regs #(
    parameter int W = pwm_chan_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_stage,
    input  logic         wr_per,
    input  logic [W-1:0] wdata,
    input  logic         xfer,
    output logic [W-1:0] a_live,
    output logic [W-1:0] b_val
);
    logic [W-1:0] a_stage;

    // Software-facing staging register for A.
    always_ff @(posedge clk) begin
        if (!rst_n)        a_stage <= '0;
        else if (wr_stage) a_stage <= wdata;
    end

    // Live A value, loaded only at the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)    a_live <= '0;
        else if (xfer) a_live <= a_stage;
    end

    // B compare value, written directly.
    always_ff @(posedge clk) begin
        if (!rst_n)      b_val <= '0;
        else if (wr_per) b_val <= wdata;
    end

    // R6: transfer copies the staged value
    a_r6_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> (a_live == $past(a_stage)));
    // R6: without a boundary the live value does not move
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> $stable(a_live));
endmodule

// File: rtl/pwm_out_ctrl.sv
`timescale 1ns/1ps
// Module pwm_out_ctrl
// Turns match events into the pin state and the sticky period flag.
// A takes precedence over B only in the sense that a joint event keeps
// the pin inactive.
module pwm_out_ctrl
    import pwm_chan_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  match_ev_t ev,
    input  logic      clr,
    input  logic      pol,
    output logic      pin,
    output logic      flag
);
    logic active;

    // Active state of the pin, updated by match events.
    always_ff @(posedge clk) begin
        if (!rst_n)                    active <= 1'b0;
        else if (ev.hit_a && ev.hit_b) active <= 1'b0;
        else if (ev.hit_a)             active <= 1'b1;
        else if (ev.hit_b)             active <= 1'b0;
    end

    // Sticky flag; a set wins over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (ev.hit_b) flag <= 1'b1;
        else if (clr)      flag <= 1'b0;
    end

    assign pin = active ^ pol;

    // R3: lone A match drives the pin active
    a_r3_a_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (ev.hit_a && !ev.hit_b) |=> active);
    // R5: joint match leaves the pin inactive
    a_r5_joint_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (ev.hit_a && ev.hit_b) |=> !active);
    // R7: B match sets the flag even with a clear present
    a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        ev.hit_b |=> flag);
    // R7: the flag holds until cleared
    a_r7_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
endmodule

// File: rtl/pwm_match_chan.sv
`timescale 1ns/1ps
// Module pwm_match_chan
// Top of the buffered match PWM channel: two edge match detectors,
// compare registers with A staging, and the pin/flag controller.
// Assumes the count bus comes from an external shared counter.
module pwm_match_chan
    import pwm_chan_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt_bus,
    input  logic         tick_en,
    input  logic         wr_stage_a,
    input  logic         wr_period_b,
    input  logic [W-1:0] wr_data,
    input  logic         flag_clr,
    input  logic         out_pol,
    output logic         pwm_out,
    output logic         match_flag
);
    logic [W-1:0]       a_live;
    logic [W-1:0]       b_val;
    logic [W-1:0]       cmp_sel [N_MATCH];
    logic [N_MATCH-1:0] hits;
    match_ev_t          ev;

    assign cmp_sel[IDX_A] = a_live;
    assign cmp_sel[IDX_B] = b_val;

    // One edge detector per compare value.
    for (genvar g = 0; g < N_MATCH; g++) begin : g_match
        pwm_edge_match #(.W(W)) u_match (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick_en),
            .bus   (cnt_bus),
            .cmp   (cmp_sel[g]),
            .hit   (hits[g])
        );
    end

    assign ev.hit_a = hits[IDX_A];
    assign ev.hit_b = hits[IDX_B];

    pwm_cmp_regs #(.W(W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stage (wr_stage_a),
        .wr_per   (wr_period_b),
        .wdata    (wr_data),
        .xfer     (ev.hit_b),
        .a_live   (a_live),
        .b_val    (b_val)
    );

    pwm_out_ctrl u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .ev    (ev),
        .clr   (flag_clr),
        .pol   (out_pol),
        .pin   (pwm_out),
        .flag  (match_flag)
    );

    // R9: with no tick no event reaches the controller
    a_r9_idle_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |-> (hits == '0));
endmodule

// File: tb/pwm_match_chan_bench.sv
`timescale 1ns/1ps
// Bench for pwm_match_chan: behavioural model compared every clock plus
// directed checks per requirement.
module pwm_match_chan_bench;
    localparam int W = 24;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cnt_bus = '0;
    logic         tick_en = 1'b0;
    logic         wr_stage_a = 1'b0;
    logic         wr_period_b = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         flag_clr = 1'b0;
    logic         out_pol = 1'b0;
    logic         pwm_out;
    logic         match_flag;

    int checks = 0;
    int errors = 0;
    bit free_run = 1'b0;
    int period = 10;

    // model state
    int m_a1 = 0, m_a2 = 0, m_b = 0;
    bit m_pa = 0, m_pb = 0, m_act = 0, m_flag = 0;

    always #2.5 clk = ~clk;

    pwm_match_chan #(.W(W)) u_pwm_match_chan (
        .clk(clk), .rst_n(rst_n), .cnt_bus(cnt_bus), .tick_en(tick_en),
        .wr_stage_a(wr_stage_a), .wr_period_b(wr_period_b), .wr_data(wr_data),
        .flag_clr(flag_clr), .out_pol(out_pol), .pwm_out(pwm_out),
        .match_flag(match_flag)
    );

    // Behavioural reference, evaluated on each rising edge.
    always @(posedge clk) begin
        int c;
        bit ea, eb, qa, qb;
        c = int'(cnt_bus);
        if (!rst_n) begin
            m_a1 = 0; m_a2 = 0; m_b = 0;
            m_pa = 0; m_pb = 0; m_act = 0; m_flag = 0;
        end else begin
            qa = (c == m_a1);
            qb = (c == m_b);
            ea = tick_en && qa && !m_pa;
            eb = tick_en && qb && !m_pb;
            if (tick_en) begin m_pa = qa; m_pb = qb; end
            if (ea && eb) m_act = 0;
            else if (ea)  m_act = 1;
            else if (eb)  m_act = 0;
            if (eb) m_flag = 1;
            else if (flag_clr) m_flag = 0;
            if (eb) m_a1 = m_a2;
            if (wr_stage_a)  m_a2 = int'(wr_data);
            if (wr_period_b) m_b  = int'(wr_data);
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clock: compare at the falling edge, then apply pending stimulus.
    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(pwm_out == (m_act ^ out_pol), "R3/R4 pin vs model", pwm_out, m_act ^ out_pol);
            check(match_flag == m_flag, "R7 flag vs model", match_flag, m_flag);
            wr_stage_a = 1'b0;
            wr_period_b = 1'b0;
            if (free_run) begin
                if (tick_en) cnt_bus = W'((int'(cnt_bus) + 1) % period);
                tick_en = ~tick_en;
            end
        end
    endtask

    task automatic write_a(input int v);
        wr_stage_a = 1'b1; wr_data = W'(v); run(1);
    endtask

    task automatic write_b(input int v);
        wr_period_b = 1'b1; wr_data = W'(v); run(1);
    endtask

    initial begin
        #(2.5 * 2 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit seen;
        int bad;
        logic keep_pin, keep_flag;

        run(3);
        rst_n = 1'b1;
        check(pwm_out == out_pol, "R1 pin after reset", pwm_out, out_pol);
        check(match_flag == 1'b0, "R1 flag after reset", match_flag, 0);

        // R10 / R6: program B directly and stage A, then free run
        write_b(8);
        write_a(3);
        free_run = 1'b1;
        seen = 0;
        for (int i = 0; i < 60; i++) begin
            run(1);
            if (pwm_out != out_pol) seen = 1;
        end
        check(seen, "R3 pin reached active level", seen, 1);
        check(match_flag == 1'b1, "R7 flag set by B match", match_flag, 1);
        check(m_b == 8, "R10 B applied", m_b, 8);

        // R6: stage A=6 at start of a period; old A=3 still rules this period
        while (!(cnt_bus == 0 && tick_en)) run(1);
        write_a(6);
        while (!(cnt_bus == 5 && tick_en)) run(1);
        check(pwm_out == ~out_pol, "R6 old A still live", pwm_out, ~out_pol);
        while (!(cnt_bus == 9 && tick_en)) run(1);
        while (!(cnt_bus == 5 && tick_en)) run(1);
        check(pwm_out == out_pol, "R6 new A live after boundary", pwm_out, out_pol);

        // R8: polarity change visible at once
        out_pol = 1'b1;
        #1;
        check(pwm_out == (m_act ^ 1'b1), "R8 polarity immediate", pwm_out, m_act ^ 1'b1);
        run(30);

        // R7: clear held through a B match; set must win
        flag_clr = 1'b1;
        seen = 0;
        for (int i = 0; i < 24; i++) begin
            run(1);
            if (match_flag) seen = 1;
        end
        flag_clr = 1'b0;
        check(seen, "R7 set wins over clear", seen, 1);

        // R9: no tick, sweep bus across both compare values
        free_run = 1'b0;
        tick_en = 1'b0;
        run(1);
        keep_pin = pwm_out;
        keep_flag = match_flag;
        for (int v = 0; v < 10; v++) begin
            cnt_bus = W'(v);
            run(1);
        end
        check(pwm_out == keep_pin, "R9 pin unchanged without tick", pwm_out, keep_pin);
        check(match_flag == keep_flag, "R9 flag unchanged without tick", match_flag, keep_flag);

        // R2: bus held at B over many ticks gives one event
        tick_en = 1'b1;
        cnt_bus = W'(7);
        flag_clr = 1'b1;
        run(2);
        flag_clr = 1'b0;
        cnt_bus = W'(8);
        run(1);
        check(match_flag == 1'b1, "R2 first equal tick is an event", match_flag, 1);
        flag_clr = 1'b1;
        run(1);
        flag_clr = 1'b0;
        run(5);
        check(match_flag == 1'b0, "R2 held equality gives no new event", match_flag, 0);

        // R5: A equal to B, pin must never leave the inactive level
        cnt_bus = W'(0);
        write_a(5);
        write_b(5);
        free_run = 1'b1;
        run(60);
        bad = 0;
        for (int i = 0; i < 80; i++) begin
            run(1);
            if (pwm_out != out_pol) bad++;
        end
        check(bad == 0, "R5 zero duty with equal A and B", bad, 0);

        // R4: restore A before B, and check B returns pin inactive after count 8
        write_a(2);
        write_b(8);
        run(60);
        while (!(cnt_bus == 9 && tick_en)) run(1);
        run(1);
        check(pwm_out == out_pol, "R4 B match returns pin inactive", pwm_out, out_pol);

        // R1: reset again mid-run
        rst_n = 1'b0;
        run(2);
        check(pwm_out == out_pol, "R1 pin on reset", pwm_out, out_pol);
        check(match_flag == 1'b0, "R1 flag on reset", match_flag, 0);
        rst_n = 1'b1;
        run(10);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule